// File: doc/BRIEF.md
# Rectangular Frame-Memory Pixel Transfer Engine

This block copies a rectangle of 16-bit pixels between a 32-bit host data stream and a frame memory addressed as 1024 columns by 512 rows. A three-word command arms it. The first word selects the direction, the second gives the top-left corner and the third gives the rectangle size. The block then walks the rectangle in row-major order and moves two pixels for each data word. The data may arrive, or be requested, in bursts with idle cycles between them. The walk position is kept between bursts, so a burst that stops part-way along a row carries on at the same column when the next one starts.

Writes can force the top (mask) bit of every stored pixel to 1, and can leave alone any destination pixel whose mask bit is already set. A read raises an image-ready status until the last pixel has been delivered. A completed write produces a one-cycle frame-dirty pulse when the rectangle overlaps the display window. The frame store is an internal array with one column and row address per pixel. Its parameters choose how many low address bits it keeps, and a full-size instance keeps all of them. Arming a new transfer before the current one is finished drops the current one and sets a sticky error flag.

Top module: `vram_xfer_engine`

## Requirements
- R1: On the command port, a word whose bits 31:29 are 101 arms a write and 110 arms a read. Any other first word is ignored and leaves both data ports not ready. The next two command words are the corner (X in bits 9:0, Y in bits 24:16) and the size (width in bits 9:0, height in bits 24:16). Each size field is decremented, masked to its own width and then incremented, so a width of 0 means 1024 and a height of 0 means 512.
- R2: Each data word holds two pixels, with bits 15:0 first and bits 31:16 second. Pixels run in row-major order and are counted one at a time, so a row may end in the middle of a word. When the pixel total is odd, the upper half of the final write word is discarded and the upper half of the final read word is 0.
- R3: Idle cycles between data words, in either direction, do not change the pixel order. The transfer resumes at the exact column where it stopped.
- R4: Row numbers wrap modulo 512 as the walk moves down the rectangle.
- R5: When mask_ctl bit 0 is 1 during a write, bit 15 of every stored pixel is set.
- R6: When mask_ctl bit 1 is 1 during a write, any destination pixel that already has bit 15 set keeps its old value.
- R7: image_ready goes high once a read is armed. It stays high while the read is active and falls when the word holding the last pixel is accepted.
- R8: frame_dirty pulses high for one cycle, after the final word of a write is accepted, only when the rectangle overlaps the window given by scan_x/scan_y/disp_w/disp_h.
- R9: Arming a transfer while another is unfinished abandons the old transfer and sets xfer_err, which stays set until reset.
- R10: wr_ready is high only during an active write and rd_ready only during an active read. rd_valid and rd_data appear exactly one cycle after an accepted rd_req.
- R11: After reset, no transfer is active, both ready outputs are low, and image_ready, frame_dirty, xfer_err and rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Command, corner or size word |
| mask_ctl | input | 2 | Bit 0 forces the mask bit, bit 1 protects masked pixels |
| scan_x | input | 10 | Display window left column |
| scan_y | input | 9 | Display window top row |
| disp_w | input | 11 | Display window width |
| disp_h | input | 10 | Display window height |
| wr_valid | input | 1 | Write data word present |
| wr_data | input | 32 | Two pixels to write |
| wr_ready | output | 1 | Write word accepted this cycle |
| rd_req | input | 1 | Request one read word |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_valid | output | 1 | rd_data holds a word |
| rd_data | output | 32 | Two pixels read |
| image_ready | output | 1 | Read in progress |
| frame_dirty | output | 1 | Completed write touched the display window |
| xfer_err | output | 1 | Sticky flag for an abandoned transfer |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the two ready outputs are never high together, that read data follows an accepted request exactly one cycle later and at no other time, that image_ready covers every active read, that the error flag is sticky, and that a dirty pulse comes only right after an accepted write word, with the transfer already over. Pixel placement can only be shown by the bench scenarios, which write and then read back. These cover an odd row length that breaks mid-word, gaps in bursts, row wrap past 511, both mask rules, the window edges for the dirty pulse, and a zero size field that means the maximum.

// File: rtl/vxfer_pkg.sv
// Shared types for the pixel transfer engine.
// Assumes a logical frame of 1024 columns by 512 rows.
package vxfer_pkg;
    localparam int XW = 10;  // column coordinate bits
    localparam int YW = 9;   // row coordinate bits

    // Walk position inside the rectangle; rows == 0 means idle.
    typedef struct packed {
        logic [XW:0]   off;   // column offset inside the row
        logic [YW-1:0] y;     // current absolute row
        logic [YW:0]   rows;  // rows left, including the current one
    } cur_t;

    typedef enum logic [1:0] {CP_OP, CP_POS, CP_SIZE} cphase_t;

    // Advance one pixel along the rectangle; row wraps at 512 by width.
    function automatic cur_t cur_step(cur_t c, logic [XW:0] w);
        cur_t n;
        n = c;
        if (c.rows != '0) begin
            if (c.off + 1'b1 == w) begin
                n.off  = '0;
                n.y    = c.y + 1'b1;
                n.rows = c.rows - 1'b1;
            end else begin
                n.off = c.off + 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/vxfer_store.sv
// Frame store: two combinational read ports, two synchronous write ports.
// Assumes both writes in one cycle target different addresses.
module vxfer_store #(
    parameter int ABITS = 11
) (
    input  logic             clk,
    input  logic [ABITS-1:0] ra0,
    input  logic [ABITS-1:0] ra1,
    output logic [15:0]      rd0,
    output logic [15:0]      rd1,
    input  logic             we0,
    input  logic             we1,
    input  logic [ABITS-1:0] wa0,
    input  logic [ABITS-1:0] wa1,
    input  logic [15:0]      wd0,
    input  logic [15:0]      wd1
);
    localparam int DEPTH = 1 << ABITS;

    logic [15:0] mem [DEPTH];

    // Read ports used for both fetch and mask checking.
    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];

    // Pixel writes for the two halves of a word.
    always_ff @(posedge clk) begin
        if (we0) mem[wa0] <= wd0;
        if (we1) mem[wa1] <= wd1;
    end
endmodule

// File: rtl/vxfer_walker.sv
// Holds the rectangle walk position and looks one and two pixels ahead.
// Assumes load and adv are never high together (load wins).
module vxfer_walker
    import vxfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  cur_t        load_val,
    input  logic        adv,
    input  logic [XW:0] w,
    output cur_t        cur,
    output cur_t        nxt1,
    output cur_t        nxt2
);
    assign nxt1 = cur_step(cur, w);
    assign nxt2 = cur_step(nxt1, w);

    // Position register: reload on arm, move two pixels per word.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= load_val;
        else if (adv)  cur <= nxt2;
    end
endmodule

// File: rtl/vxfer_overlap.sv
// Tests whether two axis-aligned rectangles share any pixel.
// Assumes no wrap: edges are summed in widened arithmetic.
module vxfer_overlap
    import vxfer_pkg::*;
(
    input  logic [XW-1:0] ax,
    input  logic [YW-1:0] ay,
    input  logic [XW:0]   aw,
    input  logic [YW:0]   ah,
    input  logic [XW-1:0] bx,
    input  logic [YW-1:0] by,
    input  logic [XW:0]   bw,
    input  logic [YW:0]   bh,
    output logic          hit
);
    logic [XW+1:0] a_r, b_r;
    logic [YW+1:0] a_b, b_b;

    // Right and bottom edges, exclusive.
    always_comb begin
        a_r = {2'b0, ax} + {1'b0, aw};
        b_r = {2'b0, bx} + {1'b0, bw};
        a_b = {2'b0, ay} + {1'b0, ah};
        b_b = {2'b0, by} + {1'b0, bh};
        hit = ({2'b0, ax} < b_r) && ({2'b0, bx} < a_r) &&
              ({2'b0, ay} < b_b) && ({2'b0, by} < a_b);
    end
endmodule

// File: rtl/vram_xfer_engine.sv
// Rectangle pixel mover between a 32-bit data port and the frame store.
// Takes three command words, then moves two pixels per handshake.
// Assumes mask_ctl and the display window are steady during a transfer.
module vram_xfer_engine
    import vxfer_pkg::*;
#(
    parameter int COL_BITS = 6,  // column address bits kept in storage
    parameter int ROW_BITS = 5   // row address bits kept in storage
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    input  logic [1:0]  mask_ctl,
    input  logic [9:0]  scan_x,
    input  logic [8:0]  scan_y,
    input  logic [10:0] disp_w,
    input  logic [9:0]  disp_h,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    input  logic        rd_req,
    output logic        rd_ready,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        image_ready,
    output logic        frame_dirty,
    output logic        xfer_err
);
    localparam int ABITS = COL_BITS + ROW_BITS;

    cphase_t       phase;
    logic          pend_rd, act_rd;
    logic [XW-1:0] px, ax0;
    logic [YW-1:0] py, ay0;
    logic [XW:0]   aw;
    logic [YW:0]   ah;

    logic          arm, active, wr_go, rd_go, p1_ok, last, hit;
    logic [XW-1:0] arm_wm1;
    logic [YW-1:0] arm_hm1;
    logic [XW:0]   arm_w;
    logic [YW:0]   arm_h;
    cur_t          arm_cur, cur, nxt1, nxt2;
    logic [XW-1:0] col0, col1;
    logic [ABITS-1:0] a0, a1;
    logic [15:0]   old0, old1, new0, new1;
    logic          we0, we1;

    // Size decode: zero field means the maximum extent.
    always_comb begin
        arm     = cmd_valid && (phase == CP_SIZE);
        arm_wm1 = cmd_word[XW-1:0] - 1'b1;
        arm_hm1 = cmd_word[16+YW-1:16] - 1'b1;
        arm_w   = {1'b0, arm_wm1} + 1'b1;
        arm_h   = {1'b0, arm_hm1} + 1'b1;
        arm_cur = '{off: '0, y: py, rows: arm_h};
    end

    // Handshake: arming takes the cycle, so no data moves then.
    always_comb begin
        active   = (cur.rows != '0);
        wr_ready = active && !act_rd && !arm;
        rd_ready = active &&  act_rd && !arm;
        wr_go    = wr_valid && wr_ready;
        rd_go    = rd_req && rd_ready;
        p1_ok    = (nxt1.rows != '0);
        last     = (nxt2.rows == '0);
    end

    // Pixel addresses: column wraps at 1024, storage keeps low bits.
    always_comb begin
        col0 = ax0 + cur.off[XW-1:0];
        col1 = ax0 + nxt1.off[XW-1:0];
        a0   = {cur.y[ROW_BITS-1:0],  col0[COL_BITS-1:0]};
        a1   = {nxt1.y[ROW_BITS-1:0], col1[COL_BITS-1:0]};
    end

    // Write data with mask force and mask protect rules.
    always_comb begin
        new0 = wr_data[15:0]  | {mask_ctl[0], 15'b0};
        new1 = wr_data[31:16] | {mask_ctl[0], 15'b0};
        we0  = wr_go && !(mask_ctl[1] && old0[15]);
        we1  = wr_go && p1_ok && !(mask_ctl[1] && old1[15]);
    end

    // Command sequencer: opcode, corner, size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= CP_OP;
            pend_rd <= 1'b0;
            px      <= '0;
            py      <= '0;
        end else if (cmd_valid) begin
            unique case (phase)
                CP_OP: begin
                    if (cmd_word[31:29] == 3'b101) begin
                        pend_rd <= 1'b0;
                        phase   <= CP_POS;
                    end else if (cmd_word[31:29] == 3'b110) begin
                        pend_rd <= 1'b1;
                        phase   <= CP_POS;
                    end
                end
                CP_POS: begin
                    px    <= cmd_word[XW-1:0];
                    py    <= cmd_word[16+YW-1:16];
                    phase <= CP_SIZE;
                end
                default: phase <= CP_OP;
            endcase
        end
    end

    // Active transfer descriptor, captured on arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_rd <= 1'b0;
            ax0    <= '0;
            ay0    <= '0;
            aw     <= '0;
            ah     <= '0;
        end else if (arm) begin
            act_rd <= pend_rd;
            ax0    <= px;
            ay0    <= py;
            aw     <= arm_w;
            ah     <= arm_h;
        end
    end

    // Read return path: fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= {(p1_ok ? old1 : 16'h0000), old0};
        end
    end

    // Status flags: image ready, dirty pulse, sticky abandon error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            image_ready <= 1'b0;
            frame_dirty <= 1'b0;
            xfer_err    <= 1'b0;
        end else begin
            if (arm)                image_ready <= pend_rd;
            else if (rd_go && last) image_ready <= 1'b0;
            frame_dirty <= wr_go && last && hit;
            xfer_err    <= xfer_err || (arm && active);
        end
    end

    vxfer_walker u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (arm_cur),
        .adv      (wr_go || rd_go),
        .w        (aw),
        .cur      (cur),
        .nxt1     (nxt1),
        .nxt2     (nxt2)
    );

    vxfer_store #(.ABITS(ABITS)) u_store (
        .clk (clk),
        .ra0 (a0),
        .ra1 (a1),
        .rd0 (old0),
        .rd1 (old1),
        .we0 (we0),
        .we1 (we1),
        .wa0 (a0),
        .wa1 (a1),
        .wd0 (new0),
        .wd1 (new1)
    );

    vxfer_overlap u_ovl (
        .ax  (ax0),
        .ay  (ay0),
        .aw  (aw),
        .ah  (ah),
        .bx  (scan_x),
        .by  (scan_y),
        .bw  (disp_w),
        .bh  (disp_h),
        .hit (hit)
    );
endmodule

// File: rtl/vram_xfer_engine_chk.sv
// Port-level protocol checker for vram_xfer_engine, attached by bind.
// Assumes reset is held for at least one clock before use.
module vram_xfer_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_req,
    input logic rd_ready,
    input logic rd_valid,
    input logic image_ready,
    input logic frame_dirty,
    input logic xfer_err
);
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && rd_ready)); // R10
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> rd_valid); // R10
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && rd_ready) |=> !rd_valid); // R10
    AST_IMG_COVERS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> image_ready); // R7
    AST_IMG_MEANS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (image_ready && !cmd_valid) |-> rd_ready); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> xfer_err); // R9
    AST_DIRTY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_dirty |-> $past(wr_valid && wr_ready)); // R8
    AST_DIRTY_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_dirty |-> !wr_ready); // R8
endmodule

bind vram_xfer_engine vram_xfer_engine_chk u_chk (.*);

// File: tb/vram_xfer_engine_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module vram_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [1:0]  mask_ctl = 2'b00;
    logic [9:0]  scan_x = 10'd0;
    logic [8:0]  scan_y = 9'd0;
    logic [10:0] disp_w = 11'd16;
    logic [9:0]  disp_h = 10'd8;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        rd_req = 1'b0;
    logic        rd_ready, rd_valid, image_ready, frame_dirty, xfer_err;
    logic [31:0] rd_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vram_xfer_engine u_dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic arm(input bit rd, input [9:0] x, input [8:0] y, input [9:0] wf, input [8:0] hf);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = rd ? 32'hC000_0000 : 32'hA000_0000;
        @(negedge clk);
        cmd_word  = {7'b0, y, 6'b0, x};
        @(negedge clk);
        cmd_word  = {7'b0, hf, 6'b0, wf};
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic put(input logic [31:0] d, input string req);
        check(wr_ready === 1'b1, req, {31'b0, wr_ready}, 32'd1);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic get(output logic [31:0] d, input string req);
        check(rd_ready === 1'b1, req, {31'b0, rd_ready}, 32'd1);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid === 1'b1, "R10 latency", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic expect_word(input logic [31:0] exp, input string req);
        logic [31:0] d;
        get(d, req);
        check(d === exp, req, d, exp);
    endtask

    task automatic t_reset;
        check(wr_ready === 1'b0 && rd_ready === 1'b0, "R11 ready", {30'b0, wr_ready, rd_ready}, 32'd0);
        check({image_ready, frame_dirty, xfer_err, rd_valid} === 4'b0, "R11 flags",
              {28'b0, image_ready, frame_dirty, xfer_err, rd_valid}, 32'd0);
    endtask

    task automatic t_basic;
        arm(1'b0, 10'd3, 9'd2, 10'd4, 9'd2);
        for (int k = 0; k < 4; k++) put({16'h1001 + 16'(2 * k), 16'h1000 + 16'(2 * k)}, "R2 write");
        check(frame_dirty === 1'b1, "R8 overlap pulse", {31'b0, frame_dirty}, 32'd1);
        @(negedge clk);
        check(frame_dirty === 1'b0, "R8 single cycle", {31'b0, frame_dirty}, 32'd0);
        check(wr_ready === 1'b0, "R10 write done", {31'b0, wr_ready}, 32'd0);
        arm(1'b1, 10'd3, 9'd2, 10'd4, 9'd2);
        check(image_ready === 1'b1, "R7 set on arm", {31'b0, image_ready}, 32'd1);
        for (int k = 0; k < 3; k++) expect_word({16'h1001 + 16'(2 * k), 16'h1000 + 16'(2 * k)}, "R2 readback");
        check(image_ready === 1'b1, "R7 held", {31'b0, image_ready}, 32'd1);
        expect_word(32'h1007_1006, "R2 readback");
        check(image_ready === 1'b0 && rd_ready === 1'b0, "R7 cleared at end", {30'b0, image_ready, rd_ready}, 32'd0);
    endtask

    task automatic t_odd;
        arm(1'b0, 10'd10, 9'd5, 10'd4, 9'd1);
        put(32'h0D0D_0D0D, "R2 fill");
        put(32'h0D0D_0D0D, "R2 fill");
        arm(1'b0, 10'd10, 9'd5, 10'd3, 9'd1);
        put(32'hB00B_A00A, "R2 odd");
        put(32'h7777_C00C, "R2 odd");
        check(wr_ready === 1'b0, "R2 odd ends", {31'b0, wr_ready}, 32'd0);
        arm(1'b1, 10'd10, 9'd5, 10'd4, 9'd1);
        expect_word(32'hB00B_A00A, "R2 odd");
        expect_word(32'h0D0D_C00C, "R2 upper half discarded");
        arm(1'b1, 10'd10, 9'd5, 10'd3, 9'd1);
        expect_word(32'hB00B_A00A, "R2 odd read");
        expect_word(32'h0000_C00C, "R2 odd read zero half");
    endtask

    task automatic t_burst;
        arm(1'b0, 10'd50, 9'd10, 10'd5, 9'd2);
        for (int k = 0; k < 5; k++) begin
            put({16'h2001 + 16'(2 * k), 16'h2000 + 16'(2 * k)}, "R3 burst write");
            repeat (k + 1) @(negedge clk);
        end
        arm(1'b1, 10'd50, 9'd10, 10'd5, 9'd2);
        for (int k = 0; k < 5; k++) begin
            repeat (3) @(negedge clk);
            expect_word({16'h2001 + 16'(2 * k), 16'h2000 + 16'(2 * k)}, "R3 resume");
        end
    endtask

    task automatic t_wrap;
        arm(1'b0, 10'd20, 9'd511, 10'd2, 9'd3);
        for (int k = 0; k < 3; k++) put({16'h3001 + 16'(2 * k), 16'h3000 + 16'(2 * k)}, "R4 write");
        arm(1'b1, 10'd20, 9'd0, 10'd2, 9'd2);
        expect_word(32'h3003_3002, "R4 row 0");
        expect_word(32'h3005_3004, "R4 row 1");
        arm(1'b1, 10'd20, 9'd511, 10'd2, 9'd1);
        expect_word(32'h3001_3000, "R4 row 511");
    endtask

    task automatic t_mask;
        mask_ctl = 2'b01;
        arm(1'b0, 10'd30, 9'd20, 10'd2, 9'd1);
        put(32'h0002_0001, "R5 write");
        mask_ctl = 2'b00;
        arm(1'b1, 10'd30, 9'd20, 10'd2, 9'd1);
        expect_word(32'h8002_8001, "R5 forced");
        arm(1'b0, 10'd40, 9'd20, 10'd2, 9'd1);
        put(32'h0006_8005, "R6 seed");
        mask_ctl = 2'b10;
        arm(1'b0, 10'd40, 9'd20, 10'd2, 9'd1);
        put(32'h2222_1111, "R6 write");
        mask_ctl = 2'b00;
        arm(1'b1, 10'd40, 9'd20, 10'd2, 9'd1);
        expect_word(32'h2222_8005, "R6 protected");
    endtask

    task automatic t_dirty;
        arm(1'b0, 10'd50, 9'd10, 10'd2, 9'd1);
        put(32'h0101_0101, "R8 outside");
        check(frame_dirty === 1'b0, "R8 outside no pulse", {31'b0, frame_dirty}, 32'd0);
        arm(1'b0, 10'd16, 9'd0, 10'd1, 9'd1);
        put(32'h0000_0444, "R8 edge");
        check(frame_dirty === 1'b0, "R8 right edge no pulse", {31'b0, frame_dirty}, 32'd0);
        arm(1'b0, 10'd15, 9'd7, 10'd1, 9'd1);
        put(32'h0000_0555, "R8 corner");
        check(frame_dirty === 1'b1, "R8 last pixel pulse", {31'b0, frame_dirty}, 32'd1);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word = 32'h0200_0000;
        @(negedge clk);
        cmd_word = 32'h0000_0005;
        @(negedge clk);
        cmd_word = 32'h0000_0002;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(wr_ready === 1'b0 && rd_ready === 1'b0, "R1 unknown opcode", {30'b0, wr_ready, rd_ready}, 32'd0);
    endtask

    task automatic t_abandon;
        arm(1'b0, 10'd0, 9'd30, 10'd4, 9'd1);
        put(32'h0909_0909, "R9 partial");
        check(xfer_err === 1'b0, "R9 no error yet", {31'b0, xfer_err}, 32'd0);
        arm(1'b1, 10'd3, 9'd2, 10'd2, 9'd1);
        check(xfer_err === 1'b1, "R9 error set", {31'b0, xfer_err}, 32'd1);
        check(wr_ready === 1'b0 && rd_ready === 1'b1, "R9 new transfer", {30'b0, wr_ready, rd_ready}, 32'd1);
        expect_word(32'h1001_1000, "R9 new read");
        repeat (4) @(negedge clk);
        check(xfer_err === 1'b1, "R9 sticky", {31'b0, xfer_err}, 32'd1);
    endtask

    task automatic t_maxsize;
        logic [31:0] d;
        arm(1'b1, 10'd3, 9'd2, 10'd1, 9'd0);
        for (int k = 0; k < 255; k++) get(d, "R1 zero height");
        check(image_ready === 1'b1, "R1 512 rows pending", {31'b0, image_ready}, 32'd1);
        get(d, "R1 zero height");
        check(image_ready === 1'b0, "R1 512 rows done", {31'b0, image_ready}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_odd();
        t_burst();
        t_wrap();
        t_mask();
        t_dirty();
        t_ignored();
        t_abandon();
        t_maxsize();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule